// File: doc/BRIEF.md
# USB Charger Detection Sequencer

This block runs the charging-port detection phase of USB battery-charger detection. A single-cycle pulse on the start input marks that the data pins have made contact. The sequencer then waits one millisecond so the lines can settle. It enables three analog units together: the voltage source on D+, the current sink on D–, and the D– comparator. When a programmable number of milliseconds has elapsed, the sequencer samples two digital comparator outputs, turns all three units off, and classifies the attached port.

Time is measured by counting a one-cycle millisecond tick that a shared timebase supplies. Software talks to the block through a small word-wide register port. It programs the sampling interval, reads the result code, enables the interrupt, clears the completion flag, and can force the sequencer back to idle with a software reset.

Top module: `chgdet_seq`

## Requirements
- R1: After a start pulse while idle, the three analog enables stay low until one millisecond tick has been counted. They go high on the clock edge that takes that tick.
- R2: The D+ source enable, the D– sink enable and the D– comparator enable are always equal.
- R3: The interval register (address 1, bits [9:0]) reads 40 after reset and can be written. With a value N ≥ 1, the enables remain high through N−1 ticks after the settle tick.
- R4: On the edge that takes the N-th tick of the interval, the comparators are sampled and all enables drop.
- R5: The result code (address 2, bits [1:0]) is set from the sampled comparators. It is 2'b11 when D– is above the logic threshold, whether or not it is above the reference. It is 2'b10 when D– is above the reference only. It is 2'b01 (standard host) when D– is above neither.
- R6: The result code is 2'b00 after reset and is cleared to 2'b00 when a new sequence starts.
- R7: Completion sets the flag at address 0 bit 1. The flag stays set until a write of 1 to that bit clears it. A write of 0 to that bit leaves it unchanged.
- R8: The interrupt output equals the flag AND the interrupt-enable bit (address 0 bit 0).
- R9: Writing 1 to address 0 bit 2 returns the sequencer to idle. It drops the enables and clears both the result code and the flag in the same edge.
- R10: A start pulse that arrives while a sequence is in progress is ignored and does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| contact_evt | input | 1 | Data-pin contact pulse that starts a sequence |
| dm_above_ref | input | 1 | D– comparator: above lower reference |
| dm_above_logic | input | 1 | D– comparator: above logic threshold |
| dp_src_en | output | 1 | D+ voltage source enable |
| dm_sink_en | output | 1 | D– current sink enable |
| dm_cmp_en | output | 1 | D– comparator enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
Every result is registered exactly once. The enables, the result code, the flag and the interrupt all change on the same edge that takes the start pulse, the deciding tick, or the register write, and none of them is delayed further. The bench drives each stimulus for one cycle from a falling edge and checks the outputs at the next falling edge, after exactly one rising edge. Between ticks it inserts an idle cycle, so each tick is counted on a single known edge. This lets the bench predict the tick on which the enables rise and fall for every interval from 1 to 5 and for the default of 40, under each of the four comparator patterns.

// File: rtl/chgdet_seq.sv
module chgdet_seq #(
  parameter int CNT_W        = 10,
  parameter int SETTLE_MS    = 1,
  parameter int INTERVAL_RST = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ms_tick,
  input  logic        contact_evt,
  input  logic        dm_above_ref,
  input  logic        dm_above_logic,
  output logic        dp_src_en,
  output logic        dm_sink_en,
  output logic        dm_cmp_en,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_DETECT} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   interval;
  logic [1:0]         result_q;
  logic               flag_q;
  logic               ie_q;

  logic               wr_ctrl, wr_intv, swrst;
  logic [CNT_W:0]     cnt_nxt;
  logic               settle_done, detect_done;
  logic [1:0]         code;

  assign wr_ctrl     = reg_wr && reg_addr == 2'd0;
  assign wr_intv     = reg_wr && reg_addr == 2'd1;
  assign swrst       = wr_ctrl && reg_wdata[2];
  assign cnt_nxt     = {1'b0, cnt} + 1'b1;
  assign settle_done = cnt_nxt >= (CNT_W+1)'(SETTLE_MS);
  assign detect_done = cnt_nxt >= {1'b0, interval};
  assign code        = dm_above_logic ? 2'b11 : (dm_above_ref ? 2'b10 : 2'b01);

  assign dp_src_en  = state == S_DETECT;
  assign dm_sink_en = state == S_DETECT;
  assign dm_cmp_en  = state == S_DETECT;
  assign irq        = flag_q & ie_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {13'd0, 1'b0, flag_q, ie_q};
      2'd1:    reg_rdata = 16'(interval);
      2'd2:    reg_rdata = {14'd0, result_q};
      default: reg_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      interval <= CNT_W'(INTERVAL_RST);
      result_q <= 2'b00;
      flag_q   <= 1'b0;
      ie_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ie_q <= reg_wdata[0];
      if (wr_intv) interval <= reg_wdata[CNT_W-1:0];
      if (wr_ctrl && reg_wdata[1]) flag_q <= 1'b0;
      if (swrst) begin
        state    <= S_IDLE;
        cnt      <= '0;
        result_q <= 2'b00;
        flag_q   <= 1'b0;
      end else begin
        case (state)
          S_IDLE:
            if (contact_evt) begin
              state    <= S_SETTLE;
              cnt      <= '0;
              result_q <= 2'b00;
            end
          S_SETTLE:
            if (ms_tick) begin
              if (settle_done) begin
                state <= S_DETECT;
                cnt   <= '0;
              end else cnt <= cnt_nxt[CNT_W-1:0];
            end
          S_DETECT:
            if (ms_tick) begin
              if (detect_done) begin
                state    <= S_IDLE;
                cnt      <= '0;
                result_q <= code;
                flag_q   <= 1'b1;
              end else cnt <= cnt_nxt[CNT_W-1:0];
            end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/chgdet_seq_chk.sv
module chgdet_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       dm_above_ref,
  input logic       dm_above_logic,
  input logic       dp_src_en,
  input logic       dm_sink_en,
  input logic       dm_cmp_en,
  input logic       swrst,
  input logic [1:0] result_q,
  input logic       flag_q
);
  AST_ENABLES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_src_en == dm_sink_en) && (dm_sink_en == dm_cmp_en)); // R2
  AST_ON_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_src_en) |-> $past(ms_tick)); // R1
  AST_OFF_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_src_en) |-> ($past(ms_tick) || $past(swrst))); // R4
  AST_CLASSIFY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dp_src_en) && !$past(swrst)) |->
      result_q == ($past(dm_above_logic) ? 2'b11 : ($past(dm_above_ref) ? 2'b10 : 2'b01))); // R5
  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dp_src_en) && !$past(swrst)) |-> flag_q); // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(swrst) |-> (!dp_src_en && result_q == 2'b00 && !flag_q)); // R9
endmodule

bind chgdet_seq chgdet_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
  .dm_above_ref(dm_above_ref), .dm_above_logic(dm_above_logic),
  .dp_src_en(dp_src_en), .dm_sink_en(dm_sink_en), .dm_cmp_en(dm_cmp_en),
  .swrst(swrst), .result_q(result_q), .flag_q(flag_q)
);

// File: tb/test_chgdet_seq.sv
`timescale 1ns/1ps
module test_chgdet_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0, contact_evt = 1'b0;
  logic        dm_above_ref = 1'b0, dm_above_logic = 1'b0;
  logic        dp_src_en, dm_sink_en, dm_cmp_en, irq;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chgdet_seq i_chgdet_seq (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic tick();
    ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_code(bit lo, bit hi);
    return hi ? 3 : (lo ? 2 : 1);
  endfunction

  function automatic int en3();
    return (dp_src_en && dm_sink_en && dm_cmp_en) ? 1 : ((dp_src_en || dm_sink_en || dm_cmp_en) ? 2 : 0);
  endfunction

  task automatic start();
    contact_evt = 1'b1; @(negedge clk); contact_evt = 1'b0;
  endtask

  task automatic run_seq(int n, bit lo, bit hi, bit ie);
    int v;
    wr(2'd0, {13'd0, 1'b0, 1'b1, ie});
    wr(2'd1, 16'(n));
    dm_above_ref = lo; dm_above_logic = hi;
    start();
    rd(2'd2, v); chk("R6 result cleared at start", v, 0);
    idle(2);
    chk("R1 enables low before settle tick", en3(), 0);
    tick();
    chk("R1 R2 all enables high after settle tick", en3(), 1);
    for (int k = 1; k <= n; k++) begin
      idle(1);
      tick();
      if (k < n) chk("R3 enables held during interval", en3(), 1);
    end
    chk("R4 enables low after N-th tick", en3(), 0);
    rd(2'd2, v); chk("R5 result code", v, exp_code(lo, hi));
    rd(2'd0, v); chk("R7 flag set on completion", (v >> 1) & 1, 1);
    chk("R8 irq equals flag and enable", int'(irq), int'(ie));
  endtask

  initial begin
    int v;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R3 reset state enables", en3(), 0);
    rd(2'd1, v); chk("R3 interval default", v, 40);
    rd(2'd2, v); chk("R6 result after reset", v, 0);
    chk("R8 irq after reset", int'(irq), 0);

    run_seq(40, 1'b1, 1'b0, 1'b1);

    for (int n = 1; n <= 5; n++)
      for (int c = 0; c < 4; c++)
        run_seq(n, c[0], c[1], c[0] ^ c[1] ^ n[0]);

    // R7: write 0 keeps flag, write 1 clears; R8 follows
    wr(2'd0, 16'h0001);
    rd(2'd0, v); chk("R7 write 0 keeps flag", (v >> 1) & 1, 1);
    chk("R8 irq with flag and enable", int'(irq), 1);
    wr(2'd0, 16'h0000);
    chk("R8 irq masked by enable", int'(irq), 0);
    wr(2'd0, 16'h0003);
    rd(2'd0, v); chk("R7 write 1 clears flag", (v >> 1) & 1, 0);
    chk("R8 irq low after clear", int'(irq), 0);

    // R10: start pulses during settle and detect are ignored
    wr(2'd1, 16'd3);
    dm_above_ref = 1'b0; dm_above_logic = 1'b0;
    start();
    start();
    chk("R10 still waiting after extra start", en3(), 0);
    tick();
    chk("R10 detect begins on first tick", en3(), 1);
    tick();
    start();
    tick();
    chk("R10 enables held despite start", en3(), 1);
    tick();
    chk("R10 completion on original schedule", en3(), 0);
    rd(2'd2, v); chk("R10 R5 standard host code", v, 1);

    // R9: soft reset during detect
    wr(2'd1, 16'd5);
    start();
    tick();
    tick();
    chk("R9 in detect before soft reset", en3(), 1);
    wr(2'd0, 16'h0004);
    chk("R9 enables low after soft reset", en3(), 0);
    rd(2'd2, v); chk("R9 result cleared", v, 0);
    rd(2'd0, v); chk("R9 flag cleared", (v >> 1) & 1, 0);
    idle(1);
    tick();
    chk("R9 stays idle after soft reset", en3(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule